// File: doc/BRIEF.md
# Infrared Pulse-to-Bit Decoder

This block turns a sliced, active-high infrared pulse stream into the serial line that a UART receiver expects. The raw line is first brought into the system clock domain. A filter then accepts a pulse only after the line has stayed high for a programmable number of consecutive clocks. The moment a pulse is accepted, a one-shot pulls the decoded line low for exactly one bit time. With no pulse, the line stays high, which is the UART mark level. Each received pulse therefore becomes a logic-0 bit.

Analog front ends with high gain often ring. A single light pulse can then arrive as a main pulse followed a few microseconds later by an echo. The one-shot refuses any new pulse during the first half of its window, so such echoes are absorbed. A pulse that arrives in the second half starts a fresh full window, so back-to-back zero bits are never lost. At run time the bit time is set in clocks (for example, 800 clocks for 15 kbaud at 12 MHz) and so is the filter length (for example, 4 clocks for about 300 ns). A debug strobe marks every pulse that the lockout swallowed.

Top module: `irda_pulse_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the decoder ends any window. After that edge `rx_bit_o` is 1 and `echo_drop_o` is 0, and no window resumes after `rst` falls.
- R2: A pulse qualifies only when the synchronised input stays high for L consecutive clocks, where L is `filt_len_i` and a value of 0 counts as 1. A shorter pulse leaves `rx_bit_o` at 1. A pulse that stays high longer qualifies only once.
- R3: A qualifying pulse that arrives with no window active drives `rx_bit_o` low. The output falls at the clock L+3 clocks after the raw rising edge. It stays low for exactly D clocks, where D is `bit_div_i` and values below 2 count as 2.
- R4: When no window is active, `rx_bit_o` is 1.
- R5: Let two qualification events be k clocks apart. If k is at most floor(D/2), the second event is ignored and the window still ends D clocks after the first event.
- R6: If k is greater than floor(D/2), the second event restarts a full window. `rx_bit_o` then stays low for k+D clocks in total.
- R7: D is sampled when a window starts from idle. A change to `bit_div_i` during a window does not change that window. The new value applies to the next window.
- R8: `echo_drop_o` is high for one clock for each event ignored under R5, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_rx_i | input | 1 | Sliced infrared line, high while a pulse is present |
| bit_div_i | input | DIV_W (16) | Bit time in clocks |
| filt_len_i | input | FLT_W (8) | Minimum qualifying pulse width in clocks |
| rx_bit_o | output | 1 | Decoded serial line: low for one bit time per pulse, idle high |
| echo_drop_o | output | 1 | One-clock strobe for each pulse ignored by the first-half lockout |

## Verification
Suppose the window counter or the lockout compare is wrong. The low time of `rx_bit_o` then becomes wrong by one or more clocks, and the error shows at the end of the very first window. Each vector measures that low time against k+D or D. Suppose instead the filter or synchroniser has the wrong depth. The falling edge then moves away from L+3 clocks after the raw edge, and the bench checks this latency on every qualifying vector. An error in the lockout decision shows in two places at once: a wrong total low time, and a wrong count of `echo_drop_o` strobes over the same vector.

// File: rtl/irda_dec_pkg.sv
package irda_dec_pkg;
   // Smallest bit time the one-shot accepts, so that a half window exists.
   localparam int unsigned MIN_BIT_CLKS = 2;
   // Fewest synchroniser flops allowed.
   localparam int unsigned MIN_SYNC     = 2;
endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   import irda_dec_pkg::*;

   if (STAGES < MIN_SYNC) begin : g_bad_stages
      $error("irda_sync: STAGES must be at least MIN_SYNC");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irda_glitch_filter.sv
module irda_glitch_filter #(
   parameter int unsigned FLT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_i,
   input  logic [FLT_W-1:0] len_i,
   output logic             qual_o
);
   if (FLT_W < 1) begin : g_bad_width
      $error("irda_glitch_filter: FLT_W must be at least 1");
   end

   logic [FLT_W-1:0] run_q;
   logic [FLT_W-1:0] len_eff;
   logic             qual_q;

   assign len_eff = (len_i == '0) ? FLT_W'(1) : len_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= '0;
         qual_q <= 1'b0;
      end else begin
         qual_q <= rx_i && (run_q < len_eff) && ((run_q + FLT_W'(1)) == len_eff);
         if (!rx_i)                run_q <= '0;
         else if (run_q < len_eff) run_q <= run_q + FLT_W'(1);
      end
   end

   assign qual_o = qual_q;

   // R2: a qualification always follows a high sample of the line
   a_r2_qual_needs_high: assert property (@(posedge clk) disable iff (rst)
      qual_q |-> $past(rx_i));
   // R2: a held-high pulse qualifies only once
   a_r2_single_qual: assert property (@(posedge clk) disable iff (rst)
      qual_q |=> !qual_q);
endmodule

// File: rtl/irda_oneshot.sv
module irda_oneshot #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             qual_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             win_o,
   output logic             echo_o
);
   import irda_dec_pkg::*;

   if (DIV_W < 2) begin : g_bad_width
      $error("irda_oneshot: DIV_W must be at least 2");
   end

   localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_BIT_CLKS);

   logic             act_q, echo_q;
   logic [DIV_W-1:0] t_q, div_q, div_eff, half;
   logic             lock, retrig;

   assign div_eff = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;
   assign half    = div_q >> 1;
   assign lock    = act_q && qual_i && (t_q < half);
   assign retrig  = act_q && qual_i && !lock;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q  <= 1'b0;
         t_q    <= '0;
         div_q  <= DIV_FLOOR;
         echo_q <= 1'b0;
      end else begin
         echo_q <= lock;
         if (qual_i && !act_q) begin
            act_q <= 1'b1;
            t_q   <= '0;
            div_q <= div_eff;
         end else if (retrig) begin
            t_q <= '0;
         end else if (act_q) begin
            if (t_q == div_q - DIV_W'(1)) begin
               act_q <= 1'b0;
               t_q   <= '0;
            end else begin
               t_q <= t_q + DIV_W'(1);
            end
         end
      end
   end

   assign win_o  = act_q;
   assign echo_o = echo_q;

   // R3: a pulse seen while idle opens a window from count zero
   a_r3_start: assert property (@(posedge clk) disable iff (rst)
      (qual_i && !act_q) |=> (act_q && t_q == '0));
   // R3: the elapsed count stays inside the latched bit time
   a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
      act_q |-> (t_q < div_q));
   // R5: a locked-out pulse neither restarts nor ends the window
   a_r5_lockout: assert property (@(posedge clk) disable iff (rst)
      lock |=> (act_q && t_q == $past(t_q) + DIV_W'(1)));
   // R6: a second-half pulse restarts the count
   a_r6_retrigger: assert property (@(posedge clk) disable iff (rst)
      retrig |=> (act_q && t_q == '0));
   // R7: the bit time is frozen for the life of a window
   a_r7_div_frozen: assert property (@(posedge clk) disable iff (rst)
      (act_q && $past(act_q)) |-> $stable(div_q));
   // R8: the echo strobe is a single clock
   a_r8_echo_single: assert property (@(posedge clk) disable iff (rst)
      echo_q |=> !echo_q);
endmodule

// File: rtl/irda_pulse_decoder.sv
module irda_pulse_decoder #(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned FLT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ir_rx_i,
   input  logic [DIV_W-1:0] bit_div_i,
   input  logic [FLT_W-1:0] filt_len_i,
   output logic             rx_bit_o,
   output logic             echo_drop_o
);
   logic rx_sync, qual, win;

   irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_i(ir_rx_i), .q_o(rx_sync)
   );

   irda_glitch_filter #(.FLT_W(FLT_W)) u_filt (
      .clk(clk), .rst(rst), .rx_i(rx_sync), .len_i(filt_len_i), .qual_o(qual)
   );

   irda_oneshot #(.DIV_W(DIV_W)) u_shot (
      .clk(clk), .rst(rst), .qual_i(qual), .div_i(bit_div_i),
      .win_o(win), .echo_o(echo_drop_o)
   );

   assign rx_bit_o = ~win;

   // R1: the cycle after reset the line is idle
   a_r1_reset_idle: assert property (@(posedge clk)
      $past(rst) |-> (rx_bit_o && !echo_drop_o));
   // R8: a dropped echo happens only inside a window
   a_r8_echo_in_window: assert property (@(posedge clk) disable iff (rst)
      echo_drop_o |-> !rx_bit_o);
endmodule

// File: tb/irda_pulse_decoder_tb.sv
`timescale 1ns/1ps
module irda_pulse_decoder_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ir_rx = 1'b0;
   logic [15:0] bit_div = 16'd40;
   logic [7:0]  filt_len = 8'd4;
   logic        rx_bit, echo_drop;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irda_pulse_decoder u_dut (
      .clk(clk), .rst(rst), .ir_rx_i(ir_rx), .bit_div_i(bit_div),
      .filt_len_i(filt_len), .rx_bit_o(rx_bit), .echo_drop_o(echo_drop)
   );

   // w1, gap, w2, div, len, expected low clocks, expected drops, requirement
   localparam int NV = 13;
   localparam int VEC [NV][8] = '{
      '{96, 84, 60, 800, 4, 800, 1, 5},  // 8/7/5 us echo at 12 MHz, 15 kbaud
      '{ 6,  0,  0,  40, 4,  40, 0, 3},
      '{ 3,  0,  0,  40, 4,   0, 0, 2},  // too short
      '{ 4,  0,  0,  40, 4,  40, 0, 2},  // exactly L
      '{ 5, 15,  5,  40, 4,  40, 1, 5},  // k=20 = D/2, locked
      '{ 5, 16,  5,  40, 4,  61, 0, 6},  // k=21, retrigger
      '{ 5, 16,  5,  41, 4,  62, 0, 6},  // odd D
      '{ 6, 25,  2,  40, 4,  40, 0, 2},  // second pulse too short
      '{60,  0,  0,  40, 4,  40, 0, 2},  // long pulse qualifies once
      '{ 1,  0,  0,  30, 1,  30, 0, 2},  // L=1
      '{ 6,  0,  0,   1, 4,   2, 0, 3},  // D clamp
      '{ 5,  5,  5,  40, 4,  40, 1, 8},  // early echo strobe
      '{ 5, 20,  5,  40, 2,  65, 0, 6}
   };

   function automatic string rq(int r);
      case (r)
         1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
         5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int w1, gap, w2, div, len, chg_at, chg_val,
                           output int lowc, first, drops);
      int dmax = (div < 2) ? 2 : div;
      int span = w1 + gap + w2 + 2 * dmax + 2 * (chg_val + 1) + len + 12;
      @(negedge clk);
      bit_div  = 16'(div);
      filt_len = 8'(len);
      lowc = 0; first = -1; drops = 0;
      for (int c = 0; c < span; c++) begin
         @(negedge clk);
         if (!rx_bit) begin
            lowc++;
            if (first < 0) first = c;
         end
         if (echo_drop) drops++;
         if (c == chg_at) bit_div = 16'(chg_val);
         ir_rx = (c < w1) || (c >= w1 + gap && c < w1 + gap + w2);
      end
      ir_rx = 1'b0;
   endtask

   initial begin
      int lowc, first, drops, leff;
      repeat (4) @(negedge clk);
      // R1/R4: state after reset
      check("R1", "rx_bit in reset", int'(rx_bit), 1);
      check("R1", "echo_drop in reset", int'(echo_drop), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R4", "idle rx_bit", int'(rx_bit), 1);

      for (int i = 0; i < NV; i++) begin
         run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], -1, 0,
                  lowc, first, drops);
         check(rq(VEC[i][7]), $sformatf("vector %0d low clocks", i), lowc, VEC[i][5]);
         check(VEC[i][6] > 0 ? "R8" : rq(VEC[i][7]),
               $sformatf("vector %0d echo strobes", i), drops, VEC[i][6]);
         if (VEC[i][5] > 0) begin
            leff = (VEC[i][4] == 0) ? 1 : VEC[i][4];
            check("R3", $sformatf("vector %0d fall latency", i), first, leff + 3);
         end
      end

      // R7: divisor change inside a window
      run_case(6, 0, 0, 40, 4, 20, 100, lowc, first, drops);
      check("R7", "window keeps latched divisor", lowc, 40);
      run_case(6, 0, 0, 100, 4, -1, 0, lowc, first, drops);
      check("R7", "next window uses new divisor", lowc, 100);

      // R1: reset in the middle of a window
      @(negedge clk);
      bit_div = 16'd40;
      ir_rx = 1'b1;
      repeat (6) @(negedge clk);
      ir_rx = 1'b0;
      repeat (6) @(negedge clk);
      check("R1", "window open before reset", int'(rx_bit), 0);
      rst = 1'b1;
      @(negedge clk);
      check("R1", "reset ends window", int'(rx_bit), 1);
      rst = 1'b0;
      lowc = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (!rx_bit) lowc++;
      end
      check("R1", "no window after reset", lowc, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule